// File: doc/BRIEF.md
# NAND Byte-Register Transfer Sequencer

This block carries out single-byte transfers between a NAND flash device and a 32-bit register split into four byte slots. Each instruction produces exactly one strobe on the flash bus. The instruction may send an address byte, send a data byte, read one status byte, or read one status byte after the device reports ready. Outgoing bytes come from the `wr_data` word. Incoming bytes land in the `rd_data` word.

The outgoing and incoming directions each keep their own slot pointer. Both pointers start at slot 0 and step by one per transfer. Address and data sends share the outgoing pointer. Once an outgoing pointer has passed slot 3, sends put 0x00 on the bus. Once the incoming pointer has passed slot 3, received bytes are dropped. A `clear` pulse at the start of each command sequence sets both pointers back to slot 0. Strobe low and recovery widths are set by the parameters `LO_CYC` and `HI_CYC`.

The controller is a five-state machine:
- IDLE accepts an instruction. It goes to POLL for the wait-ready read and to SETUP for every other opcode.
- POLL samples the synchronized ready/busy line. It goes to SETUP when the line is high. It goes back to IDLE, with a timeout, after `tmo_limit` cycles of low samples.
- SETUP drives data and the address latch for one cycle, then goes to STROBE.
- STROBE holds the selected strobe low for `LO_CYC` cycles, then goes to HOLD.
- HOLD keeps data and latch levels for `HI_CYC` cycles, then goes back to IDLE.

Top module: `nand_breg_seq`

## Requirements
- R1: After reset the strobes are inactive: `nand_we_n`=1, `nand_re_n`=1, `nand_ale`=0, `nand_cle`=0. In the same state `nand_dq_oe`, `busy`, `done` and `tmo_err` are 0, and `rd_data` is 0.
- R2: Opcode 0 (address send) gives exactly one `nand_we_n` low pulse. During that pulse `nand_ale` is 1, `nand_cle` is 0, and `nand_dq_out` carries the byte at the outgoing pointer.
- R3: Opcode 1 (data send) gives exactly one `nand_we_n` low pulse. During that pulse `nand_ale` and `nand_cle` are 0, and `nand_dq_out` carries the byte at the outgoing pointer.
- R4: Opcodes 0 and 1 share one outgoing pointer, which advances once per send. Slot k is `wr_data[8k+7:8k]`, sampled when the instruction is accepted. The fifth and later sends drive 0x00.
- R5: Opcode 2 (status read) gives exactly one `nand_re_n` low pulse with `nand_dq_oe` low. It stores `nand_dq_in` into `rd_data[8k+7:8k]`, where k is the incoming pointer. After four reads, further read bytes are dropped and `rd_data` is unchanged.
- R6: The incoming pointer moves only on reads and the outgoing pointer moves only on sends. Interleaving the two does not shift either.
- R7: Opcode 3 (wait-ready read) pulses `nand_re_n` only after `nand_rb` has been seen high through a two-flop synchronizer. It then behaves as opcode 2.
- R8: If `nand_rb` stays low for `tmo_limit` polling cycles (`tmo_limit` ≥ 1), opcode 3 ends with no read strobe, `done` pulses and `tmo_err` goes to 1. On a timeout the incoming pointer does not move. `tmo_err` is cleared by the next accepted instruction or by `clear`.
- R9: An instruction is accepted when `op_valid` is 1, the block is idle and `clear` is 0. `busy` is 1 from the cycle after acceptance until strobe recovery ends. A send or a plain read takes 1+`LO_CYC`+`HI_CYC` busy cycles. `done` is then 1 for exactly one cycle, with `busy` back at 0.
- R10: `clear` returns both pointers to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Sequence start: both pointers back to slot 0 |
| op_valid | input | 1 | Instruction request |
| op_code | input | 2 | 0 address send, 1 data send, 2 status read, 3 wait-ready status read |
| wr_data | input | 32 | Outgoing byte slots |
| tmo_limit | input | TMO_W | Ready-poll timeout in cycles |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| tmo_err | output | 1 | Last wait-ready read timed out |
| rd_data | output | 32 | Incoming byte slots |
| nand_cle | output | 1 | Command latch enable (held low) |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_out | output | 8 | Flash data bus, outgoing |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_in | input | 8 | Flash data bus, incoming |
| nand_rb | input | 1 | Ready/busy from the flash, high when ready |

## Verification
The hardest corner to reach from the ports is the edge of the ready wait. There, the synchronizer delay and the timeout count decide whether a read strobe appears at all. The bench raises `nand_rb` at chosen negative edges counted from acceptance, across a range of delays. It also holds `nand_rb` low against timeouts of one to five cycles. After each timeout, a follow-up plain read shows whether the incoming pointer stayed put. The pointer ceilings are reached by sweeping every six-instruction mix of sends and reads after a `clear`.

// File: rtl/nbs_pkg.sv
package nbs_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WDAT  = 2'd1,
        OP_RSTAT = 2'd2,
        OP_RWAIT = 2'd3
    } nbs_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } nbs_state_e;

endpackage

// File: rtl/nbs_sync.sv
module nbs_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= 1'b0;
            q    <= 1'b0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/nbs_slot_ptr.sv
module nbs_slot_ptr #(
    parameter int SLOTS = 4,
    parameter int PW    = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] CEIL = PW'(SLOTS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (clr)
            ptr <= '0;
        else if (step && ptr != CEIL)
            ptr <= ptr + PW'(1);
    end

    // R4 / R5: pointer saturates at the slot count
    a_r4_ptr_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= CEIL);
endmodule

// File: rtl/nbs_byte_pick.sv
module nbs_byte_pick #(
    parameter int SLOTS = 4,
    parameter int BW    = 8,
    parameter int PW    = 3
) (
    input  logic [SLOTS*BW-1:0] word,
    input  logic [PW-1:0]       ptr,
    output logic [BW-1:0]       byte_o
);
    always_comb begin
        byte_o = '0;
        for (int k = 0; k < SLOTS; k++) begin
            if (ptr == PW'(k))
                byte_o = word[k*BW +: BW];
        end
    end
endmodule

// File: rtl/nand_breg_seq.sv
module nand_breg_seq
    import nbs_pkg::*;
#(
    parameter int SLOTS  = 4,
    parameter int BW     = 8,
    parameter int LO_CYC = 2,
    parameter int HI_CYC = 1,
    parameter int TMO_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                op_valid,
    input  logic [1:0]          op_code,
    input  logic [SLOTS*BW-1:0] wr_data,
    input  logic [TMO_W-1:0]    tmo_limit,
    output logic                busy,
    output logic                done,
    output logic                tmo_err,
    output logic [SLOTS*BW-1:0] rd_data,
    output logic                nand_cle,
    output logic                nand_ale,
    output logic                nand_we_n,
    output logic                nand_re_n,
    output logic [BW-1:0]       nand_dq_out,
    output logic                nand_dq_oe,
    input  logic [BW-1:0]       nand_dq_in,
    input  logic                nand_rb
);
    localparam int PW    = $clog2(SLOTS + 1);
    localparam int PH_MX = (LO_CYC > HI_CYC) ? LO_CYC : HI_CYC;
    localparam int PH_W  = $clog2(PH_MX + 1);
    localparam logic [PH_W-1:0] LO_LAST = PH_W'(LO_CYC - 1);
    localparam logic [PH_W-1:0] HI_LAST = PH_W'(HI_CYC - 1);

    nbs_state_e         state, nstate;
    nbs_op_e            op_q;
    logic [PH_W-1:0]    ph_cnt;
    logic [TMO_W-1:0]   poll_cnt;
    logic [BW-1:0]      dq_q;
    logic               done_q, tmo_q;
    logic [SLOTS*BW-1:0] rd_q;
    logic               rb_s;
    logic [PW-1:0]      wr_ptr, rd_ptr;
    logic [BW-1:0]      pick;
    logic               accept, tmo_hit, strobe_end, hold_end, rd_step, wr_step;
    logic               op_is_rd;

    nbs_sync u_rb_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nand_rb),
        .q     (rb_s)
    );

    nbs_slot_ptr #(.SLOTS(SLOTS), .PW(PW)) u_wr_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .step  (wr_step),
        .ptr   (wr_ptr)
    );

    nbs_slot_ptr #(.SLOTS(SLOTS), .PW(PW)) u_rd_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clear),
        .step  (rd_step),
        .ptr   (rd_ptr)
    );

    nbs_byte_pick #(.SLOTS(SLOTS), .BW(BW), .PW(PW)) u_pick (
        .word   (wr_data),
        .ptr    (wr_ptr),
        .byte_o (pick)
    );

    assign accept     = op_valid && (state == ST_IDLE) && !clear;
    assign op_is_rd   = op_q[1];
    assign strobe_end = (state == ST_STROBE) && (ph_cnt == LO_LAST);
    assign hold_end   = (state == ST_HOLD) && (ph_cnt == HI_LAST);
    assign tmo_hit    = (state == ST_POLL) && !rb_s &&
                        (poll_cnt == tmo_limit - TMO_W'(1));
    assign wr_step    = accept && !op_code[1];
    assign rd_step    = strobe_end && op_is_rd;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE:   if (accept)
                           nstate = (nbs_op_e'(op_code) == OP_RWAIT) ? ST_POLL : ST_SETUP;
            ST_POLL:   if (rb_s)
                           nstate = ST_SETUP;
                       else if (tmo_hit)
                           nstate = ST_IDLE;
            ST_SETUP:  nstate = ST_STROBE;
            ST_STROBE: if (strobe_end) nstate = ST_HOLD;
            ST_HOLD:   if (hold_end) nstate = ST_IDLE;
            default:   nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            op_q     <= OP_ADDR;
            ph_cnt   <= '0;
            poll_cnt <= '0;
            dq_q     <= '0;
            done_q   <= 1'b0;
            tmo_q    <= 1'b0;
        end else begin
            state  <= nstate;
            done_q <= hold_end || tmo_hit;
            if (state != nstate)
                ph_cnt <= '0;
            else
                ph_cnt <= ph_cnt + PH_W'(1);
            if (accept) begin
                op_q     <= nbs_op_e'(op_code);
                dq_q     <= pick;
                poll_cnt <= '0;
            end else if (state == ST_POLL) begin
                poll_cnt <= poll_cnt + TMO_W'(1);
            end
            if (clear || accept)
                tmo_q <= 1'b0;
            else if (tmo_hit)
                tmo_q <= 1'b1;
        end
    end

    for (genvar k = 0; k < SLOTS; k++) begin : g_cap
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                rd_q[k*BW +: BW] <= '0;
            else if (rd_step && rd_ptr == PW'(k))
                rd_q[k*BW +: BW] <= nand_dq_in;
        end
    end

    always_comb begin
        logic on_bus;
        on_bus      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
        busy        = (state != ST_IDLE);
        done        = done_q;
        tmo_err     = tmo_q;
        rd_data     = rd_q;
        nand_cle    = 1'b0;
        nand_ale    = on_bus && (op_q == OP_ADDR);
        nand_dq_oe  = on_bus && !op_is_rd;
        nand_dq_out = dq_q;
        nand_we_n   = !((state == ST_STROBE) && !op_is_rd);
        nand_re_n   = !((state == ST_STROBE) && op_is_rd);
    end

    // R2/R3/R5: never both strobes at once
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(!nand_we_n && !nand_re_n));
    // R2: address latch only while the block drives the bus
    a_r2_ale_drives: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ale |-> nand_dq_oe);
    // R7: wait-ready read only strobes once ready has been seen
    a_r7_ready_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_POLL && !rb_s) |=> nand_re_n);
    // R8: timeout flag rises together with completion
    a_r8_tmo_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_err) |-> done);
    // R9: done follows a busy cycle and is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));
    a_r9_done_once: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: tb/sim_nand_breg_seq.sv
module sim_nand_breg_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [31:0] wr_data = 32'h0;
    logic [7:0]  tmo_limit = 8'd40;
    logic        busy, done, tmo_err;
    logic [31:0] rd_data;
    logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [7:0]  nand_dq_out;
    logic [7:0]  nand_dq_in = 8'h00;
    logic        nand_rb = 1'b1;

    int total = 0;
    int bad = 0;
    int t_we, t_re, t_len, t_busy_bad, t_early, t_oe_rd;
    logic t_ale, t_cle;
    logic [7:0] t_dq;
    logic [31:0] m_rd = 32'h0;

    always #2 clk = ~clk;

    nand_breg_seq u0 (
        .clk(clk), .rst_n(rst_n), .clear(clear), .op_valid(op_valid),
        .op_code(op_code), .wr_data(wr_data), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .tmo_err(tmo_err), .rd_data(rd_data),
        .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
        .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
        .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clear = 1'b1;
        @(negedge clk); clear = 1'b0;
    endtask

    // issue one instruction, watch the bus until done; rise>=0 raises ready at that negedge
    task automatic run_op(input logic [1:0] op, input int rise);
        logic pwe, pre;
        @(negedge clk);
        op_code = op; op_valid = 1'b1;
        @(posedge clk); #1 op_valid = 1'b0;
        t_we = 0; t_re = 0; t_len = 0; t_busy_bad = 0; t_early = 0; t_oe_rd = 0;
        t_ale = 1'b0; t_cle = 1'b0; t_dq = 8'hxx; pwe = 1'b1; pre = 1'b1;
        for (int n = 0; n < 300; n++) begin
            @(negedge clk);
            if (done) break;
            t_len++;
            if (n == rise) nand_rb = 1'b1;
            if (!busy) t_busy_bad++;
            if (!nand_we_n && pwe) begin t_we++; t_ale = nand_ale; t_cle = nand_cle; t_dq = nand_dq_out; end
            if (!nand_re_n && pre) begin t_re++; if (nand_dq_oe) t_oe_rd++; end
            if (!nand_re_n && !nand_rb) t_early++;
            pwe = nand_we_n; pre = nand_re_n;
        end
        if (!done) chk(1'b0, "R9 done never seen", 0, 1);
    endtask

    initial begin
        #(4 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(nand_we_n === 1'b1 && nand_re_n === 1'b1, "R1 strobes idle", {nand_we_n, nand_re_n}, 2'b11);
        chk(nand_ale === 1'b0 && nand_cle === 1'b0, "R1 latches low", {nand_ale, nand_cle}, 0);
        chk(busy === 1'b0 && done === 1'b0 && tmo_err === 1'b0, "R1 flags", {busy, done, tmo_err}, 0);
        chk(rd_data === 32'h0 && nand_dq_oe === 1'b0, "R1 rd_data/oe", rd_data, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R9 R10: every address/data mix of six sends
        for (int pat = 0; pat < 64; pat++) begin
            do_clear();
            wr_data = 32'h1F2E3D4C + pat * 32'h01030507;
            for (int i = 0; i < 6; i++) begin
                logic [7:0] e;
                e = (i < 4) ? wr_data[8*i +: 8] : 8'h00;
                run_op(pat[i] ? 2'd0 : 2'd1, -1);
                chk(t_we == 1 && t_re == 0, "R2/R3 one write strobe", t_we, 1);
                chk(t_dq === e, "R4 shared pointer byte", t_dq, e);
                chk(t_ale === pat[i] && t_cle === 1'b0, pat[i] ? "R2 ale high" : "R3 ale low", t_ale, pat[i]);
                chk(t_len == 4 && t_busy_bad == 0 && busy === 1'b0, "R9 busy span", t_len, 4);
                @(negedge clk);
                chk(done === 1'b0, "R9 done single cycle", done, 0);
            end
        end

        // R5 R6: every mix of six reads/sends, independent pointers
        for (int pat = 0; pat < 64; pat++) begin
            int wi, ri;
            do_clear();
            wi = 0; ri = 0;
            wr_data = 32'hC0DE0000 + pat * 32'h00010203;
            for (int i = 0; i < 6; i++) begin
                if (pat[i]) begin
                    nand_dq_in = 8'h11 * (i + 1) + pat[7:0];
                    run_op(2'd2, -1);
                    if (ri < 4) m_rd[8*ri +: 8] = nand_dq_in;
                    ri++;
                    chk(t_re == 1 && t_we == 0 && t_oe_rd == 0, "R5 one read strobe", t_re, 1);
                    chk(rd_data === m_rd, "R5 capture slot / R6", rd_data, m_rd);
                end else begin
                    logic [7:0] e;
                    e = (wi < 4) ? wr_data[8*wi +: 8] : 8'h00;
                    run_op(2'd1, -1);
                    wi++;
                    chk(t_dq === e, "R6 send pointer unaffected by reads", t_dq, e);
                end
            end
        end

        // R10: clear in mid sequence
        wr_data = 32'hA4B3C2D1;
        do_clear(); run_op(2'd1, -1); run_op(2'd1, -1);
        do_clear(); run_op(2'd0, -1);
        chk(t_dq === 8'hD1, "R10 clear restarts send slot", t_dq, 8'hD1);

        // R7: ready rises after various delays
        tmo_limit = 8'd40;
        for (int d = 0; d < 8; d++) begin
            nand_rb = 1'b0;
            repeat (4) @(negedge clk);
            do_clear();
            nand_dq_in = 8'h70 + d[7:0];
            run_op(2'd3, d);
            m_rd[7:0] = nand_dq_in;
            chk(t_re == 1 && t_early == 0, "R7 read after ready", t_re, 1);
            chk(rd_data === m_rd && tmo_err === 1'b0, "R7 captured", rd_data, m_rd);
        end

        // R8: timeout lengths, pointer held, flag cleared by next accept
        for (int lim = 1; lim <= 5; lim++) begin
            nand_rb = 1'b0;
            repeat (4) @(negedge clk);
            do_clear();
            tmo_limit = lim[7:0];
            run_op(2'd3, -1);
            chk(t_re == 0 && t_we == 0, "R8 no strobe on timeout", t_re, 0);
            chk(t_len == lim, "R8 timeout length", t_len, lim);
            chk(tmo_err === 1'b1, "R8 flag set", tmo_err, 1);
            nand_dq_in = 8'hE0 + lim[7:0];
            run_op(2'd2, -1);
            m_rd[7:0] = nand_dq_in;
            chk(rd_data === m_rd, "R8 read pointer unchanged", rd_data, m_rd);
            chk(tmo_err === 1'b0, "R8 flag cleared", tmo_err, 0);
        end
        nand_rb = 1'b1;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule